// File: doc/BRIEF.md
# Asynchronous Memory Bus Cycle Sequencer

This block turns one host request into one complete access on an external asynchronous 16-bit memory bus, such as a NOR flash. It drives the chip select, the word address, the read strobe, one write strobe per byte lane and the data-out enable. It also captures read data from the memory. Each access runs through five framed phases in a fixed order:

- setup
- first strobe cycle
- a run of wait cycles
- last strobe cycle
- hold

The setup, wait and hold lengths are configuration inputs, so one design can meet the chip-enable setup, access time and address hold figures of the attached part. After a write, a programmable idle gap keeps the bus quiet so that the write-high pulse width is met before the next access. An external wait input can stretch the wait phase unless a mask bit tells the block to ignore it.

The host side is a plain start/ready handshake. The host presents a word address, write data in host byte order, byte enables and a write flag. It asserts `req_valid` while `req_ready` is high. One cycle after the last strobe cycle the block pulses `rsp_done`, and for reads it returns the captured data. The configuration inputs are sampled when the request is accepted. The memory data bus is big endian: the byte at the even address travels on D15..D8.

Top module: `amb_seq`

## Requirements
- R1: After reset, and after any reset during an access, `bus_cs_n`=1, `bus_rd_n`=1, `bus_we_n`=2'b11, `bus_doe`=0, `rsp_done`=0 and `req_ready`=1.
- R2: An accepted access holds `bus_cs_n` low for exactly Th+1+Tw+1+Tf cycles. Th=`cfg_setup`, Tf=`cfg_hold`, and Tw is the effective wait count. The strobe first goes low in the (Th+1)-th chip-select cycle.
- R3: With `cfg_wait_mask`=1 the strobe stays low for exactly `cfg_wait`+2 cycles (first strobe, waits, last strobe). A wait count of zero gives two cycles.
- R4: With `cfg_wait_mask`=0, if `bus_wait` is high during the first K strobe cycles, the effective wait count is max(`cfg_wait`, K). A wait input that stays high stalls the access indefinitely. With the mask set, `bus_wait` has no effect.
- R5: `bus_addr` equals `req_addr` (word address bits ADDR_W-1..1) captured at acceptance, and stays stable for the whole time `bus_cs_n` is low.
- R6: On a write, host byte enable bit 0 (even-address byte, host data bits 7..0) drives active-low `bus_we_n[1]`, and bit 1 (odd-address byte, host bits 15..8) drives `bus_we_n[0]`. A read pulses only `bus_rd_n`, never a write strobe.
- R7: For both reads and writes, `rsp_done` is high for exactly one cycle, the cycle after the last strobe cycle. On a read, `rsp_rdata` holds the bus data captured at the end of the last strobe cycle, with D15..D8 in bits 7..0 and D7..D0 in bits 15..8.
- R8: On a write, `bus_doe` is high from the first strobe cycle through the last hold cycle (Tw+2+Tf cycles). While it is high, `bus_dout` carries the even-address byte on bits 15..8. On a read, `bus_doe` stays low.
- R9: After a write, `req_ready` stays low for `cfg_idle` cycles after `bus_cs_n` rises. After a read there is no such gap.
- R10: A request is accepted only while `req_ready` is high. Request inputs that change during a busy access affect neither the running access nor the time at which `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | SETUP_W | Setup cycles before the strobe (Th) |
| cfg_wait | input | WAIT_W | Minimum wait cycles between first and last strobe cycle |
| cfg_hold | input | HOLD_W | Hold cycles after the strobe (Tf) |
| cfg_idle | input | IDLE_W | Idle gap inserted after a write |
| cfg_wait_mask | input | 1 | 1: ignore `bus_wait` |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | ADDR_W-1 | Word address (byte address bits ADDR_W-1..1) |
| req_wdata | input | 16 | Write data, host order (bits 7..0 = even byte) |
| req_be | input | 2 | Byte enables (bit 0 = even byte) |
| req_ready | output | 1 | Idle and ready to accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, host order |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | ADDR_W-1 | Word address to memory |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 2 | Write strobes, bit 1 = D15..D8 lane |
| bus_dout | output | 16 | Write data to memory |
| bus_doe | output | 1 | Data-out enable |
| bus_din | input | 16 | Read data from memory |
| bus_wait | input | 1 | External wait request, active high |

## Verification
The hardest cases to reach from the ports are the ones where the external wait and the programmed wait count overlap. There the effective wait length is the larger of the two, and the block must leave the wait phase in exactly the right cycle. The bench drives `bus_wait` from its own count of observed strobe cycles, raising it for the first K of them. It then checks the measured strobe width against max(`cfg_wait`, K) for K both below and above the programmed count, and with the mask set. A separate run holds the wait input high until a reset arrives mid-strobe, which shows both the indefinite stall and the recovery to idle.

// File: rtl/amb_pkg.sv
package amb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_STRB1 = 3'd2,
        PH_WAIT  = 3'd3,
        PH_STRB2 = 3'd4,
        PH_HOLD  = 3'd5,
        PH_GAP   = 3'd6
    } phase_e;

    localparam int BUS_W = 16;

endpackage

// File: rtl/amb_lane_map.sv
module amb_lane_map
    import amb_pkg::*;
(
    input  logic [BUS_W-1:0] host_wdata,
    input  logic [1:0]       host_be,
    input  logic [BUS_W-1:0] bus_rdata,
    output logic [BUS_W-1:0] bus_wdata,
    output logic [1:0]       bus_lane_en,
    output logic [BUS_W-1:0] host_rdata
);
    localparam int HALF = BUS_W / 2;

    // Host order keeps the even byte low; the bus keeps it high.
    always_comb begin
        bus_wdata   = {host_wdata[HALF-1:0], host_wdata[BUS_W-1:HALF]};
        bus_lane_en = {host_be[0], host_be[1]};
        host_rdata  = {bus_rdata[HALF-1:0], bus_rdata[BUS_W-1:HALF]};
    end

endmodule

// File: rtl/amb_phase_ctl.sv
module amb_phase_ctl
    import amb_pkg::*;
#(
    parameter int SETUP_W = 4,
    parameter int WAIT_W  = 4,
    parameter int HOLD_W  = 4,
    parameter int IDLE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_wr,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic [IDLE_W-1:0]  cfg_idle,
    input  logic               cfg_wait_mask,
    input  logic               ext_wait,
    output phase_e             phase,
    output logic               is_write
);
    localparam int MAX_A = (SETUP_W > WAIT_W) ? SETUP_W : WAIT_W;
    localparam int MAX_B = (HOLD_W > IDLE_W) ? HOLD_W : IDLE_W;
    localparam int CNT_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;

    typedef struct packed {
        phase_e              ph;
        logic                wr;
        logic [CNT_W-1:0]    cnt;
        logic [WAIT_W-1:0]   tw;
        logic [HOLD_W-1:0]   tf;
        logic [IDLE_W-1:0]   gap;
        logic                mask;
    } ctl_t;

    ctl_t s_q, s_d;
    logic stretch;

    always_comb begin
        s_d     = s_q;
        stretch = !s_q.mask && ext_wait;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.wr   = start_wr;
                    s_d.tw   = cfg_wait;
                    s_d.tf   = cfg_hold;
                    s_d.gap  = cfg_idle;
                    s_d.mask = cfg_wait_mask;
                    if (cfg_setup != '0) begin
                        s_d.ph  = PH_SETUP;
                        s_d.cnt = CNT_W'(cfg_setup) - CNT_W'(1);
                    end else begin
                        s_d.ph = PH_STRB1;
                    end
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) s_d.ph = PH_STRB1;
                else s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            PH_STRB1: begin
                if (s_q.tw != '0) begin
                    s_d.ph  = PH_WAIT;
                    s_d.cnt = CNT_W'(s_q.tw) - CNT_W'(1);
                end else if (stretch) begin
                    s_d.ph  = PH_WAIT;
                    s_d.cnt = '0;
                end else begin
                    s_d.ph = PH_STRB2;
                end
            end
            PH_WAIT: begin
                if (s_q.cnt != '0) s_d.cnt = s_q.cnt - CNT_W'(1);
                else if (!stretch) s_d.ph = PH_STRB2;
            end
            PH_STRB2, PH_HOLD: begin
                if (s_q.ph == PH_STRB2 && s_q.tf != '0) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = CNT_W'(s_q.tf) - CNT_W'(1);
                end else if (s_q.ph == PH_HOLD && s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else if (s_q.wr && s_q.gap != '0) begin
                    s_d.ph  = PH_GAP;
                    s_d.cnt = CNT_W'(s_q.gap) - CNT_W'(1);
                end else begin
                    s_d.ph = PH_IDLE;
                end
            end
            PH_GAP: begin
                if (s_q.cnt == '0) s_d.ph = PH_IDLE;
                else s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.ph;
    assign is_write = s_q.wr;

endmodule

// File: rtl/amb_seq.sv
module amb_seq
    import amb_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int SETUP_W = 4,
    parameter int WAIT_W  = 4,
    parameter int HOLD_W  = 4,
    parameter int IDLE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic [IDLE_W-1:0]  cfg_idle,
    input  logic               cfg_wait_mask,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:1]  req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [1:0]         req_be,
    output logic               req_ready,
    output logic               rsp_done,
    output logic [15:0]        rsp_rdata,
    output logic               bus_cs_n,
    output logic [ADDR_W-1:1]  bus_addr,
    output logic               bus_rd_n,
    output logic [1:0]         bus_we_n,
    output logic [15:0]        bus_dout,
    output logic               bus_doe,
    input  logic [15:0]        bus_din,
    input  logic               bus_wait
);
    typedef struct packed {
        logic [ADDR_W-1:1] addr;
        logic [BUS_W-1:0]  wbus;
        logic [1:0]        lane;
        logic [BUS_W-1:0]  rdata;
        logic              done;
    } dat_t;

    dat_t   d_q, d_d;
    phase_e phase;
    logic   is_write;
    logic   accept;
    logic   strobe_on;
    logic   cs_on;
    logic [BUS_W-1:0] map_wdata;
    logic [BUS_W-1:0] map_rdata;
    logic [1:0]       map_lane;

    assign accept = req_valid && (phase == PH_IDLE);

    amb_phase_ctl #(
        .SETUP_W(SETUP_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W), .IDLE_W(IDLE_W)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (accept),
        .start_wr      (req_write),
        .cfg_setup     (cfg_setup),
        .cfg_wait      (cfg_wait),
        .cfg_hold      (cfg_hold),
        .cfg_idle      (cfg_idle),
        .cfg_wait_mask (cfg_wait_mask),
        .ext_wait      (bus_wait),
        .phase         (phase),
        .is_write      (is_write)
    );

    amb_lane_map u_lane (
        .host_wdata  (req_wdata),
        .host_be     (req_be),
        .bus_rdata   (bus_din),
        .bus_wdata   (map_wdata),
        .bus_lane_en (map_lane),
        .host_rdata  (map_rdata)
    );

    always_comb begin
        d_d      = d_q;
        d_d.done = (phase == PH_STRB2);
        if (accept) begin
            d_d.addr = req_addr;
            d_d.wbus = map_wdata;
            d_d.lane = map_lane;
        end
        if (phase == PH_STRB2 && !is_write) d_d.rdata = map_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    always_comb begin
        strobe_on = (phase == PH_STRB1) || (phase == PH_WAIT) || (phase == PH_STRB2);
        cs_on     = strobe_on || (phase == PH_SETUP) || (phase == PH_HOLD);
        req_ready = (phase == PH_IDLE);
        rsp_done  = d_q.done;
        rsp_rdata = d_q.rdata;
        bus_cs_n  = !cs_on;
        bus_addr  = d_q.addr;
        bus_rd_n  = !(strobe_on && !is_write);
        bus_we_n  = ~(d_q.lane & {2{strobe_on && is_write}});
        bus_doe   = is_write && cs_on && (phase != PH_SETUP);
        bus_dout  = d_q.wbus;
    end

endmodule

// File: rtl/amb_seq_chk.sv
module amb_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic [1:0]        bus_we_n,
    input logic [ADDR_W-1:1] bus_addr,
    input logic              bus_doe,
    input logic              rsp_done,
    input logic              req_ready
);
    logic strb;
    assign strb = !bus_rd_n || (bus_we_n != 2'b11);

    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> !bus_cs_n); // R2
    AST_CS_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> !strb); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr)); // R5
    AST_NO_MIXED_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && bus_we_n != 2'b11)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R7
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(strb)); // R7
    AST_DOE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (bus_rd_n && !bus_cs_n)); // R8
    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && !bus_doe)); // R10

endmodule

bind amb_seq amb_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_we_n  (bus_we_n),
    .bus_addr  (bus_addr),
    .bus_doe   (bus_doe),
    .rsp_done  (rsp_done),
    .req_ready (req_ready)
);

// File: tb/tb_amb_seq.sv
`timescale 1ns/1ps
module tb_amb_seq;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_setup = '0, cfg_wait = '0, cfg_hold = '0;
    logic [2:0] cfg_idle = '0;
    logic cfg_wait_mask = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:1] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_doe;
    logic [15:0] rsp_rdata, bus_dout;
    logic [AW-1:1] bus_addr;
    logic [1:0] bus_we_n;
    logic [15:0] bus_din = '0;
    logic bus_wait = 1'b0;

    int n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    amb_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_wait(cfg_wait),
        .cfg_hold(cfg_hold), .cfg_idle(cfg_idle), .cfg_wait_mask(cfg_wait_mask),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n),
        .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_wait(bus_wait)
    );

    typedef struct packed {
        logic        wr;
        logic [23:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
        logic [3:0]  th;
        logic [3:0]  tw;
        logic [3:0]  tf;
        logic [2:0]  idle;
        logic        mask;
        logic [3:0]  k;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 24'h000100, 16'hA1B2, 2'b11, 4'd1, 4'd1,  4'd1, 3'd2, 1'b1, 4'd0},
        '{1'b1, 24'h000202, 16'h3C4D, 2'b11, 4'd1, 4'd1,  4'd1, 3'd2, 1'b1, 4'd0},
        '{1'b1, 24'h123456, 16'h00EE, 2'b01, 4'd0, 4'd0,  4'd0, 3'd0, 1'b1, 4'd0},
        '{1'b1, 24'hABCDE0, 16'h7700, 2'b10, 4'd2, 4'd3,  4'd2, 3'd7, 1'b1, 4'd0},
        '{1'b0, 24'h00FFFE, 16'h1234, 2'b00, 4'd0, 4'd0,  4'd0, 3'd5, 1'b0, 4'd3},
        '{1'b0, 24'h800000, 16'hBEEF, 2'b11, 4'd3, 4'd2,  4'd0, 3'd1, 1'b0, 4'd5},
        '{1'b1, 24'h55AA54, 16'hC0DE, 2'b11, 4'd1, 4'd4,  4'd1, 3'd1, 1'b0, 4'd2},
        '{1'b0, 24'h7FFFFE, 16'h5A0F, 2'b11, 4'd2, 4'd15, 4'd3, 3'd4, 1'b1, 4'd6},
        '{1'b0, 24'h000010, 16'h0180, 2'b11, 4'd0, 4'd0,  4'd2, 3'd7, 1'b0, 4'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int tw, nstrb, first, ncs, ndoe, ndone, done_i, ready_i;
        int bad_addr, bad_dout, bad_strb;
        logic [15:0] got_rd;
        logic [1:0] exp_we;
        tw = (v.mask || v.k <= v.tw) ? int'(v.tw) : int'(v.k);
        exp_we = ~{v.be[0], v.be[1]};
        nstrb = 0; first = 0; ncs = 0; ndoe = 0; ndone = 0; done_i = 0; ready_i = 0;
        bad_addr = 0; bad_dout = 0; bad_strb = 0; got_rd = '0;
        @(negedge clk);
        cfg_setup = v.th; cfg_wait = v.tw; cfg_hold = v.tf; cfg_idle = v.idle;
        cfg_wait_mask = v.mask;
        req_write = v.wr; req_addr = v.addr[23:1]; req_wdata = v.data; req_be = v.be;
        bus_din = v.wr ? 16'h0000 : v.data;
        req_valid = 1'b1;
        chk("R10 ready before request", int'(req_ready), 1);
        @(posedge clk);
        for (int i = 1; i <= 300; i++) begin
            logic strb;
            @(negedge clk);
            if (i == 1) begin   // R10: busy-time request changes must be ignored
                req_addr = ~v.addr[23:1];
                req_write = ~v.wr;
                cfg_setup = 4'd9; cfg_hold = 4'd9;
            end
            strb = !bus_rd_n || (bus_we_n != 2'b11);
            if (strb) begin
                nstrb++;
                if (first == 0) first = i;
                if (v.wr) begin
                    if (bus_we_n !== exp_we || bus_rd_n !== 1'b1) bad_strb++;
                end else if (bus_we_n !== 2'b11) bad_strb++;
            end
            bus_wait = strb && (nstrb <= int'(v.k));
            if (!bus_cs_n) begin
                ncs++;
                if (bus_addr !== v.addr[23:1]) bad_addr++;
            end
            if (bus_doe) begin
                ndoe++;
                if (bus_dout !== {v.data[7:0], v.data[15:8]}) bad_dout++;
            end
            if (rsp_done) begin
                ndone++;
                done_i = i;
                got_rd = rsp_rdata;
            end
            if (req_ready) begin
                ready_i = i;
                req_valid = 1'b0;
                bus_wait = 1'b0;
                break;
            end
        end
        chk("R2 chip-select length", ncs, int'(v.th) + tw + int'(v.tf) + 2);
        chk("R2 strobe start", first, int'(v.th) + 1);
        chk("R3/R4 strobe width", nstrb, tw + 2);
        chk("R5 address mismatches", bad_addr, 0);
        chk("R6 strobe pattern errors", bad_strb, 0);
        chk("R7 done pulses", ndone, 1);
        chk("R7 done position", done_i, int'(v.th) + tw + 3);
        if (!v.wr) chk("R7 read data", int'(got_rd), int'({v.data[7:0], v.data[15:8]}));
        chk("R8 doe length", ndoe, v.wr ? tw + 2 + int'(v.tf) : 0);
        chk("R8 write data errors", bad_dout, 0);
        chk("R9 R10 ready return", ready_i,
            int'(v.th) + tw + int'(v.tf) + 3 + (v.wr ? int'(v.idle) : 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", int'(bus_cs_n), 1);
        chk("R1 rd_n", int'(bus_rd_n), 1);
        chk("R1 we_n", int'(bus_we_n), 3);
        chk("R1 doe", int'(bus_doe), 0);
        chk("R1 done", int'(rsp_done), 0);
        chk("R1 ready", int'(req_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int n = 0; n < NV; n++) run_vec(VEC[n]);

        // R4: wait held high stalls; R1: reset mid-access recovers
        @(negedge clk);
        cfg_setup = 4'd0; cfg_wait = 4'd0; cfg_hold = 4'd1; cfg_wait_mask = 1'b0;
        req_write = 1'b0; req_addr = 23'h1; req_valid = 1'b1; bus_wait = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R4 stalled read strobe", int'(bus_rd_n), 0);
        chk("R4 stalled chip select", int'(bus_cs_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-access cs_n", int'(bus_cs_n), 1);
        chk("R1 reset mid-access rd_n", int'(bus_rd_n), 1);
        chk("R1 reset mid-access ready", int'(req_ready), 1);
        bus_wait = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(VEC[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule